// File: doc/BRIEF.md
# Machine-Lockdown-Aware Physical Memory Permission Checker

This block decides, within one combinational path, whether a single physical memory access may proceed. It receives a small set of protection entries, each made of a configuration byte and an address word, together with the privilege side of the requester (machine or supervisor/user), the access kind (read, write or execute), the byte address and two machine security controls: a lockdown switch and a whitelist switch. It drives an allow flag and its inverse, the fault flag, which the surrounding pipeline turns into an access-fault exception.

Each entry covers a region in one of three ways: top-of-range against the previous entry's address, a single naturally aligned 4-byte word, or a naturally aligned power-of-two block. The lowest-numbered matching entry alone decides the outcome. With lockdown clear, the lock bit of an entry means "enforce on machine mode too". With lockdown set, the lock bit instead assigns the entry to the machine side or the user side, and the write-without-read encodings describe regions shared between both sides.

The interface is plain combinational logic. There is no clock, no handshake and no back-pressure: the answer follows the inputs in the same cycle, and the caller registers it where its pipeline needs it.

Top module: `pmp_mml_checker`

## Requirements
- R1: The configuration byte holds the lock bit in bit 7, the match mode in bits 4:3 (0 off, 1 top-of-range, 2 single word, 3 power-of-two block), execute in bit 2, write in bit 1 and read in bit 0; bits 6:5 have no effect. An entry in off mode never matches.
- R2: Entry addresses hold byte address bits PA_W-1:2. A top-of-range entry matches word addresses from the previous entry's address (zero for entry 0) inclusive up to its own address exclusive, and matches nothing when the previous address is not strictly below its own.
- R3: A single-word entry matches only the word equal to its address. A power-of-two entry whose address has t trailing ones covers 2^(t+1) words aligned on that size; an all-ones address covers the whole space.
- R4: When several entries match, only the lowest-numbered one decides the result.
- R5: When no entry matches, machine mode is allowed unless the whitelist switch is set, in which case it faults; supervisor/user mode always faults.
- R6: With lockdown clear and lock bit clear, a matching entry grants supervisor/user mode exactly its R, W and X bits and leaves machine mode unrestricted.
- R7: With lockdown clear and lock bit set, a matching entry grants both modes exactly its R, W and X bits.
- R8: With lockdown set and lock bit clear (lock,R,W,X written as LRWX): 0000 denies both modes; 0001 grants user execute only; codes with R=1 grant user mode its R, W, X bits and deny machine mode.
- R9: With lockdown set and lock bit set: 1000 denies both modes; 1001 grants machine execute only; codes with R=1 other than 1111 grant machine mode its R, W, X bits and deny user mode.
- R10: With lockdown set, the shared codes behave as follows: 0010 gives machine read/write and user read; 0011 gives read/write to both; 1010 gives execute to both; 1011 gives machine read/execute and user execute; 1111 gives read to both.
- R11: Access kind code 0 is read, 1 write, 2 execute; code 3 always faults. The fault output is always the inverse of the allow output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| priv_m_i | input | 1 | 1 when the requester runs in machine mode, 0 for supervisor/user |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| addr_i | input | PA_W | Physical byte address of the access |
| mml_i | input | 1 | Machine lockdown switch |
| mmwp_i | input | 1 | Whitelist switch: deny machine mode on unmatched addresses |
| cfg_i | input | 8*N_ENTRIES | Configuration bytes, entry k in bits 8k+7:8k |
| pmpaddr_i | input | (PA_W-2)*N_ENTRIES | Entry address words, entry k in slice k |
| allow_o | output | 1 | Access may proceed |
| fault_o | output | 1 | Access must raise an access fault |

## Verification
The case that matters most is region priority and the lockdown permission table acting at once: a low entry and a higher entry overlap the same word with opposite outcomes, so a wrong winner shows up only as a flipped permission under one mode and one access kind. The bench provokes this with random entries whose addresses are drawn near one another and random accesses placed inside those regions, alongside a directed pair of overlapping entries. Each result is judged against a bench model that finds the first matching entry by explicit range arithmetic and then reads its permission from a table written from the requirements.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] spare;
    amode_e     amode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_t;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rwx_t;

  localparam rwx_t RWX_NONE = 3'b000;
  localparam rwx_t RWX_ALL  = 3'b111;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_chk_pkg::*;
#(
  parameter int AW = 32
) (
  input  amode_e          amode,
  input  logic [AW-1:0]   prev_addr,
  input  logic [AW-1:0]   entry_addr,
  input  logic [AW-1:0]   word_addr,
  output logic            hit
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] addr_inc;
  logic [AW-1:0] napot_mask;
  logic          tor_valid;
  logic          tor_in;
  logic          na4_in;
  logic          napot_in;

  // The xor of an address and its successor sets every trailing one plus
  // the first zero above them: exactly the offset bits of the block.
  always_comb begin
    addr_inc   = entry_addr + ONE;
    napot_mask = ~(entry_addr ^ addr_inc);
    tor_valid  = prev_addr < entry_addr;
    tor_in     = tor_valid && (word_addr >= prev_addr) && (word_addr < entry_addr);
    na4_in     = word_addr == entry_addr;
    napot_in   = (word_addr & napot_mask) == (entry_addr & napot_mask);
  end

  always_comb begin
    unique case (amode)
      AM_TOR:   hit = tor_in;
      AM_NA4:   hit = na4_in;
      AM_NAPOT: hit = napot_in;
      default:  hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({amode, prev_addr, entry_addr, word_addr})) begin
      a_r1_off_never_hits: assert (!(amode == AM_OFF && hit))
        else $error("off entry reported a hit");
      a_r2_tor_inside: assert (!(amode == AM_TOR && hit) ||
                               (word_addr >= prev_addr && word_addr < entry_addr))
        else $error("top-of-range hit outside its bounds");
      a_r3_na4_exact: assert (!(amode == AM_NA4 && hit) || word_addr == entry_addr)
        else $error("single-word hit on another word");
    end
  end

endmodule

// File: rtl/pmp_perm_decode.sv
module pmp_perm_decode
  import pmp_chk_pkg::*;
(
  input  cfg_t  cfg,
  input  logic  mml,
  input  logic  priv_m,
  input  acc_e  acc,
  output logic  allow
);

  rwx_t own;
  rwx_t m_perm;
  rwx_t s_perm;
  rwx_t eff;
  logic [3:0] lrwx;

  always_comb begin
    own  = '{r: cfg.r, w: cfg.w, x: cfg.x};
    lrwx = {cfg.lock, cfg.r, cfg.w, cfg.x};
  end

  // Per-side permission table.
  always_comb begin
    m_perm = RWX_NONE;
    s_perm = RWX_NONE;
    if (!mml) begin
      s_perm = own;
      m_perm = cfg.lock ? own : RWX_ALL;
    end else begin
      casez (lrwx)
        4'b0000: ;
        4'b0001: s_perm = '{r: 1'b0, w: 1'b0, x: 1'b1};
        4'b0010: begin
          m_perm = '{r: 1'b1, w: 1'b1, x: 1'b0};
          s_perm = '{r: 1'b1, w: 1'b0, x: 1'b0};
        end
        4'b0011: begin
          m_perm = '{r: 1'b1, w: 1'b1, x: 1'b0};
          s_perm = '{r: 1'b1, w: 1'b1, x: 1'b0};
        end
        4'b01??: s_perm = own;
        4'b1000: ;
        4'b1001: m_perm = '{r: 1'b0, w: 1'b0, x: 1'b1};
        4'b1010: begin
          m_perm = '{r: 1'b0, w: 1'b0, x: 1'b1};
          s_perm = '{r: 1'b0, w: 1'b0, x: 1'b1};
        end
        4'b1011: begin
          m_perm = '{r: 1'b1, w: 1'b0, x: 1'b1};
          s_perm = '{r: 1'b0, w: 1'b0, x: 1'b1};
        end
        4'b1111: begin
          m_perm = '{r: 1'b1, w: 1'b0, x: 1'b0};
          s_perm = '{r: 1'b1, w: 1'b0, x: 1'b0};
        end
        4'b11??: m_perm = own;
        default: ;
      endcase
    end
  end

  always_comb begin
    eff = priv_m ? m_perm : s_perm;
    unique case (acc)
      ACC_RD:  allow = eff.r;
      ACC_WR:  allow = eff.w;
      ACC_EX:  allow = eff.x;
      default: allow = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({cfg, mml, priv_m, acc})) begin
      // R8: user-side rules with R=1 shut machine mode out.
      a_r8_user_rule_blocks_m: assert (!(mml && !cfg.lock && cfg.r && priv_m && allow))
        else $error("machine mode passed a user-side rule");
      // R9: machine-side rules with R=1 (not 1111) shut user mode out.
      a_r9_m_rule_blocks_user: assert (!(mml && cfg.lock && cfg.r && !(cfg.w && cfg.x)
                                         && !priv_m && allow))
        else $error("user mode passed a machine-side rule");
      a_r10_no_write_on_lock_shared: assert (!(mml && cfg.lock && cfg.w && !cfg.r
                                               && acc == ACC_WR && allow))
        else $error("write granted on a locked shared code region");
    end
  end

endmodule

// File: rtl/pmp_prio_select.sv
module pmp_prio_select #(
  parameter int N = 4
) (
  input  logic [N-1:0] hit,
  input  logic [N-1:0] ok,
  output logic         any_hit,
  output logic         win_ok,
  output logic [N-1:0] win
);

  always_comb begin
    win     = '0;
    any_hit = 1'b0;
    win_ok  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win     = '0;
        win[i]  = 1'b1;
        any_hit = 1'b1;
        win_ok  = ok[i];
      end
    end
  end

  always_comb begin
    if (!$isunknown({hit, ok})) begin
      a_r4_single_winner: assert ($onehot0(win))
        else $error("more than one winning entry");
      a_r4_winner_hit: assert ((win & hit) == win)
        else $error("winner did not match");
      a_r4_no_lower_hit: assert (((win - 1'b1) & hit) == '0)
        else $error("a lower matching entry was skipped");
    end
  end

endmodule

// File: rtl/pmp_mml_checker.sv
module pmp_mml_checker
  import pmp_chk_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int PA_W      = 34
) (
  input  logic                        priv_m_i,
  input  logic [1:0]                  acc_i,
  input  logic [PA_W-1:0]             addr_i,
  input  logic                        mml_i,
  input  logic                        mmwp_i,
  input  logic [CFG_W*N_ENTRIES-1:0]  cfg_i,
  input  logic [(PA_W-2)*N_ENTRIES-1:0] pmpaddr_i,
  output logic                        allow_o,
  output logic                        fault_o
);

  localparam int AW = PA_W - 2;

  acc_e            acc;
  logic [AW-1:0]   word_addr;
  logic [N_ENTRIES-1:0] hit;
  logic [N_ENTRIES-1:0] ok;
  logic [N_ENTRIES-1:0] win;
  logic            any_hit;
  logic            win_ok;
  logic            dflt_ok;

  assign acc       = acc_e'(acc_i);
  assign word_addr = addr_i[PA_W-1:2];

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_entry
    cfg_t          cfg_k;
    logic [AW-1:0] addr_k;
    logic [AW-1:0] prev_k;

    assign cfg_k  = cfg_t'(cfg_i[k*CFG_W +: CFG_W]);
    assign addr_k = pmpaddr_i[k*AW +: AW];

    if (k == 0) begin : g_first
      assign prev_k = '0;
    end else begin : g_rest
      assign prev_k = pmpaddr_i[(k-1)*AW +: AW];
    end

    pmp_region_match #(.AW(AW)) u_match (
      .amode      (cfg_k.amode),
      .prev_addr  (prev_k),
      .entry_addr (addr_k),
      .word_addr  (word_addr),
      .hit        (hit[k])
    );

    pmp_perm_decode u_perm (
      .cfg    (cfg_k),
      .mml    (mml_i),
      .priv_m (priv_m_i),
      .acc    (acc),
      .allow  (ok[k])
    );
  end

  pmp_prio_select #(.N(N_ENTRIES)) u_prio (
    .hit     (hit),
    .ok      (ok),
    .any_hit (any_hit),
    .win_ok  (win_ok),
    .win     (win)
  );

  assign dflt_ok = priv_m_i && !mmwp_i;
  assign allow_o = (acc != ACC_RSV) && (any_hit ? win_ok : dflt_ok);
  assign fault_o = !allow_o;

  always_comb begin
    if (!$isunknown({priv_m_i, acc_i, addr_i, mml_i, mmwp_i, cfg_i, pmpaddr_i})) begin
      a_r5_user_default_denied: assert (!(!any_hit && !priv_m_i && allow_o))
        else $error("user mode allowed with no matching entry");
      a_r5_whitelist_denies_m: assert (!(!any_hit && mmwp_i && allow_o))
        else $error("unmatched access allowed under whitelist");
      a_r11_reserved_kind: assert (!(acc_i == 2'd3 && allow_o))
        else $error("reserved access kind allowed");
      a_r11_fault_inverse: assert (fault_o != allow_o)
        else $error("fault and allow agree");
    end
  end

endmodule

// File: tb/test_pmp_mml_checker.sv
module test_pmp_mml_checker;

  localparam int N  = 4;
  localparam int PA = 34;
  localparam int AW = PA - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              priv_m;
  logic [1:0]        acc;
  logic [PA-1:0]     addr;
  logic              mml;
  logic              mmwp;
  logic [7:0]        cfg_a [N];
  logic [AW-1:0]     adr_a [N];
  logic [8*N-1:0]    cfg_flat;
  logic [AW*N-1:0]   adr_flat;
  logic              allow_o;
  logic              fault_o;

  int n_checks = 0;
  int n_errors = 0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_flat[i*8 +: 8]   = cfg_a[i];
      adr_flat[i*AW +: AW] = adr_a[i];
    end
  end

  pmp_mml_checker #(.N_ENTRIES(N), .PA_W(PA)) i_pmp_mml_checker (
    .priv_m_i  (priv_m),
    .acc_i     (acc),
    .addr_i    (addr),
    .mml_i     (mml),
    .mmwp_i    (mmwp),
    .cfg_i     (cfg_flat),
    .pmpaddr_i (adr_flat),
    .allow_o   (allow_o),
    .fault_o   (fault_o)
  );

  // ---------------- reference model ----------------
  function automatic logic ref_hit(int i, logic [AW-1:0] w);
    logic [1:0]  md;
    logic [63:0] lo, hi, base, size, ww;
    int t;
    md = cfg_a[i][4:3];
    ww = {32'd0, w};
    case (md)
      2'd1: begin
        lo = (i == 0) ? 64'd0 : {32'd0, adr_a[i-1]};
        hi = {32'd0, adr_a[i]};
        return (lo < hi) && (ww >= lo) && (ww < hi);
      end
      2'd2: return w == adr_a[i];
      2'd3: begin
        t = 0;
        while (t < AW && adr_a[i][t]) t++;
        size = 64'd1 << (t + 1);
        base = {32'd0, adr_a[i]} & ~(size - 64'd1);
        return (ww >= base) && (ww < base + size);
      end
      default: return 1'b0;
    endcase
  endfunction

  // returns {r,w,x} for the given side
  function automatic logic [2:0] ref_perm(logic [7:0] c, logic ml, logic pm);
    logic [3:0] code;
    logic [2:0] mp, sp, own;
    code = {c[7], c[0], c[1], c[2]};
    own  = {c[0], c[1], c[2]};
    if (!ml) begin
      sp = own;
      mp = c[7] ? own : 3'b111;
    end else begin
      case (code)
        4'b0000: begin mp = 3'b000; sp = 3'b000; end
        4'b0001: begin mp = 3'b000; sp = 3'b001; end
        4'b0010: begin mp = 3'b110; sp = 3'b100; end
        4'b0011: begin mp = 3'b110; sp = 3'b110; end
        4'b1000: begin mp = 3'b000; sp = 3'b000; end
        4'b1001: begin mp = 3'b001; sp = 3'b000; end
        4'b1010: begin mp = 3'b001; sp = 3'b001; end
        4'b1011: begin mp = 3'b101; sp = 3'b001; end
        4'b1111: begin mp = 3'b100; sp = 3'b100; end
        default: begin
          if (c[7]) begin mp = own; sp = 3'b000; end
          else      begin mp = 3'b000; sp = own; end
        end
      endcase
    end
    return pm ? mp : sp;
  endfunction

  function automatic logic ref_allow();
    logic [2:0] p;
    if (acc == 2'd3) return 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ref_hit(i, addr[PA-1:2])) begin
        p = ref_perm(cfg_a[i], mml, priv_m);
        return (acc == 2'd0) ? p[2] : (acc == 2'd1) ? p[1] : p[0];
      end
    end
    return priv_m && !mmwp;
  endfunction

  task automatic chk(string req, logic exp);
    @(negedge clk);
    #1;
    n_checks++;
    if (allow_o !== exp || fault_o !== !exp) begin
      n_errors++;
      $display("FAIL %s: allow=%b fault=%b expected allow=%b (priv_m=%b acc=%0d addr=%h mml=%b mmwp=%b)",
               req, allow_o, fault_o, exp, priv_m, acc, addr, mml, mmwp);
    end
  endtask

  task automatic clear_entries();
    for (int i = 0; i < N; i++) begin
      cfg_a[i] = 8'h00;
      adr_a[i] = '0;
    end
  endtask

  function automatic logic [PA-1:0] wa(logic [AW-1:0] w);
    return {w, 2'b00};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [2:0] p;
    string      tag;
    void'($urandom(32'd20240611));
    clear_entries();
    priv_m = 1'b1; acc = 2'd0; addr = '0; mml = 1'b0; mmwp = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: all entries off
    chk("R1", 1'b1);               // M, no match, no whitelist
    mmwp = 1'b1; chk("R5", 1'b0);  // whitelist
    mmwp = 1'b0; priv_m = 1'b0; chk("R5", 1'b0);
    priv_m = 1'b1;
    // R1: spare bits 6:5 and off mode
    cfg_a[0] = 8'h60; adr_a[0] = '1; chk("R1", 1'b1);

    // R2: top-of-range, locked, no rights
    clear_entries();
    cfg_a[0] = 8'h88; adr_a[0] = 32'h100;
    addr = wa(32'hFF);  chk("R2", 1'b0);
    addr = wa(32'h100); chk("R2", 1'b1);
    addr = wa(32'h0);   chk("R2", 1'b0);
    cfg_a[0] = 8'h00; cfg_a[1] = 8'h88; adr_a[1] = 32'h80; adr_a[0] = 32'h100;
    addr = wa(32'h90);  chk("R2", 1'b1);   // prev >= own: empty range
    adr_a[0] = 32'h40;
    addr = wa(32'h40);  chk("R2", 1'b0);
    addr = wa(32'h80);  chk("R2", 1'b1);

    // R3: single word and power-of-two
    clear_entries();
    cfg_a[0] = 8'h90; adr_a[0] = 32'h40;
    addr = wa(32'h40) | 34'd3; chk("R3", 1'b0);
    addr = wa(32'h41);         chk("R3", 1'b1);
    cfg_a[0] = 8'h98; adr_a[0] = 32'h203;
    addr = wa(32'h200); chk("R3", 1'b0);
    addr = wa(32'h207); chk("R3", 1'b0);
    addr = wa(32'h208); chk("R3", 1'b1);
    addr = wa(32'h1FF); chk("R3", 1'b1);
    adr_a[0] = '1;
    addr = wa(32'hDEAD_BEEF); chk("R3", 1'b0);

    // R4: overlapping entries, low entry wins
    clear_entries();
    cfg_a[0] = 8'h97; adr_a[0] = 32'h10;   // locked NA4 RWX
    cfg_a[1] = 8'h98; adr_a[1] = '1;       // locked NAPOT all, none
    addr = wa(32'h10); acc = 2'd1; chk("R4", 1'b1);
    addr = wa(32'h11); chk("R4", 1'b0);
    mml = 1'b1; priv_m = 1'b0; addr = wa(32'h10); chk("R4", 1'b0);
    mml = 1'b0; priv_m = 1'b1;

    // R11: reserved access kind
    clear_entries();
    acc = 2'd3; chk("R11", 1'b0);
    cfg_a[0] = 8'h1F; adr_a[0] = '1; chk("R11", 1'b0);

    // Full sweep: 16 codes x lockdown x mode x kind, one covering entry
    clear_entries();
    adr_a[0] = '1;
    addr = wa(32'h1234_5678);
    for (int code = 0; code < 16; code++) begin
      cfg_a[0] = {code[3], 2'b00, 2'b11, code[0], code[1], code[2]};
      for (int m = 0; m < 2; m++) begin
        for (int pm = 0; pm < 2; pm++) begin
          for (int k = 0; k < 3; k++) begin
            mml = m[0]; priv_m = pm[0]; acc = k[1:0];
            p = ref_perm(cfg_a[0], mml, priv_m);
            if (!mml) tag = code[3] ? "R7" : "R6";
            else if (code == 2 || code == 3 || code == 10 || code == 11 || code == 15)
              tag = "R10";
            else tag = code[3] ? "R9" : "R8";
            chk(tag, (k == 0) ? p[2] : (k == 1) ? p[1] : p[0]);
          end
        end
      end
    end

    // Random overlapping regions, judged by the model (R4 with R8/R9 mixes)
    for (int it = 0; it < 3000; it++) begin
      logic [AW-1:0] basew;
      int t;
      basew = $urandom() & 32'h0000_0FFF;
      for (int i = 0; i < N; i++) begin
        cfg_a[i] = $urandom();
        t = $urandom_range(0, 5);
        adr_a[i] = (cfg_a[i][4:3] == 2'd3)
                 ? ((basew + 32'($urandom_range(0, 63))) | ((32'd1 << t) - 32'd1))
                 : basew + 32'($urandom_range(0, 80));
      end
      addr   = wa(basew + 32'($urandom_range(0, 90))) | PA'($urandom_range(0, 3));
      priv_m = $urandom();
      acc    = $urandom_range(0, 3);
      mml    = $urandom();
      mmwp   = $urandom();
      chk("R4", ref_allow());
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule